// File: doc/BRIEF.md
# Trigger Fanout with Emulated Trigger Source

This block sits between a readout sequencer, a set of up to five detector-plane carrier boards and an external trigger unit. It copies the sequencer's control word to each active plane, so one plane or all five can be driven from the same sequencer. It also runs the trigger handshake that starts each readout: an accepted trigger raises busy toward the trigger source and sends a one-cycle start to the sequencer. Busy drops again once the sequencer reports that it is done.

Three mode bits choose the setup at run time, with no hardware change:
- the plane count;
- whether triggers come from the external unit or from a built-in emulator;
- whether readout waits for a trigger or restarts on its own after each pass.

The built-in emulator models only the trigger and busy lines. It fires after a programmable number of quiet cycles.

A software hold bit blocks new readouts without aborting one that is already running. Triggers that cannot be served are counted in a saturating counter. Mode bits are frozen while a readout is running.

Top module: `trigfan_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `seq_start`, `drop_count` and every plane output are zero. `ext_busy` is zero when real triggering is selected.
- R2: The plane outputs are registered one cycle behind `seq_ctrl`. Plane 0 (bits [7:0]) always carries the control word. Planes 1 to 4 carry it only when `cfg_five_planes` is 1, and otherwise read zero.
- R3: In triggered mode (`cfg_triggered`=1), a trigger is the selected trigger line being high in a cycle. A trigger in an idle cycle with the hold bit clear makes `busy` high and `seq_start` high in the next cycle. `seq_start` stays high for exactly that one cycle.
- R4: When `seq_done` is high in a busy cycle, `busy` is low in the next cycle. `seq_done` in an idle cycle has no effect.
- R5: In triggered mode, a trigger seen while busy or while the hold bit is set is dropped. It starts nothing and adds one to `drop_count`.
- R6: `drop_count` is 16 bits wide and stays at 65535 once it gets there.
- R7: In untriggered mode (`cfg_triggered`=0), every idle cycle with the hold bit clear starts a readout in the next cycle. Triggers in this mode are neither acted on nor counted.
- R8: A cycle with `sw_hold_we` high loads `sw_hold_d` into the hold bit, which applies from the next cycle. While the hold bit is set, no readout starts. A readout already running still ends on `seq_done`.
- R9: With `cfg_use_emu`=1, `ext_trig` is ignored and not counted, and `ext_busy` is held high. With `cfg_use_emu`=0, `ext_busy` equals `busy`.
- R10: The emulator fires in the N-th consecutive non-busy cycle, where N is `cfg_emu_period`, counting from the first idle cycle or from the cycle emulation was selected. It never fires while busy. N=0 stops it from firing.
- R11: While idle, the mode inputs and the period act in the same cycle. While busy, the values from the last idle cycle stay in force, so a change made during a readout takes effect only once busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_five_planes | input | 1 | 1: drive all five planes; 0: plane 0 only |
| cfg_use_emu | input | 1 | 1: built-in emulator is the trigger source |
| cfg_triggered | input | 1 | 1: wait for triggers; 0: free-running readout |
| cfg_emu_period | input | 16 | Emulator period in cycles (0 disables it) |
| sw_hold_we | input | 1 | Write strobe for the software hold bit |
| sw_hold_d | input | 1 | Value written into the hold bit |
| ext_trig | input | 1 | Trigger from the external trigger unit |
| ext_busy | output | 1 | Busy returned to the external trigger unit |
| seq_ctrl | input | 8 | Sequencer control word to distribute |
| seq_start | output | 1 | One-cycle readout start to the sequencer |
| seq_done | input | 1 | Sequencer reports readout complete |
| busy | output | 1 | Readout in progress |
| drop_count | output | 16 | Saturating count of dropped triggers |
| plane_ctrl | output | 40 | Control words, plane p at bits [8p+7:8p] |

## Verification
The assertions check four things on every cycle:
- `seq_start` is a single pulse that leaves the idle state and lands in a busy cycle;
- `seq_done` always ends busy;
- the drop counter only holds or steps by one, and sticks at its ceiling;
- plane 0 echoes the control word one cycle late, and busy is always visible on `ext_busy`.

Only the bench's scenarios can show the rest: the emulator's exact firing cycle, the hold bit blocking starts, freezing of the mode bits during a readout, free-running restart, and drop counting against the selected source.

// File: rtl/trigfan_pkg.sv
package trigfan_pkg;

    localparam int DROP_W   = 16;
    localparam int PERIOD_W = 16;

    typedef struct packed {
        logic five;
        logic use_emu;
        logic triggered;
    } trigfan_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } trigfan_state_t;

    // Saturating increment for the drop counter.
    function automatic logic [DROP_W-1:0] sat_inc(input logic [DROP_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    // Plane 0 is always live; the others follow the plane-count mode.
    function automatic logic plane_live(input int p, input logic five);
        return (p == 0) || five;
    endfunction

endpackage

// File: rtl/trigfan_cfg_gate.sv
module trigfan_cfg_gate
    import trigfan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                busy,
    input  trigfan_mode_t       mode_in,
    input  logic [PERIOD_W-1:0] period_in,
    output trigfan_mode_t       mode_eff,
    output logic [PERIOD_W-1:0] period_eff
);
    trigfan_mode_t       mode_q;
    logic [PERIOD_W-1:0] period_q;

    // Live while idle, frozen while a readout is running.
    always_comb begin
        mode_eff   = busy ? mode_q   : mode_in;
        period_eff = busy ? period_q : period_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            period_q <= '0;
        end else begin
            mode_q   <= mode_eff;
            period_q <= period_eff;
        end
    end
endmodule

// File: rtl/trigfan_emu.sv
module trigfan_emu
    import trigfan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                busy,
    input  logic [PERIOD_W-1:0] period,
    output logic                trig
);
    logic [PERIOD_W-1:0] cnt_q;
    logic                at_end;

    always_comb begin
        at_end = (period != '0) && (cnt_q >= period - 1'b1);
        trig   = enable && !busy && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!enable || busy || trig) begin
            cnt_q <= '0;
        end else if (!(&cnt_q)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/trigfan_ctrl.sv
module trigfan_ctrl
    import trigfan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  trigfan_mode_t     mode,
    input  logic              emu_trig,
    input  logic              ext_trig,
    input  logic              sw_hold_we,
    input  logic              sw_hold_d,
    input  logic              seq_done,
    output logic              busy,
    output logic              seq_start,
    output logic [DROP_W-1:0] drop_count
);
    trigfan_state_t    state_q, state_d;
    logic              start_q;
    logic              hold_q;
    logic [DROP_W-1:0] drop_q;
    logic              trig_sel;
    logic              launch;
    logic              lost;

    always_comb begin
        trig_sel = mode.use_emu ? emu_trig : ext_trig;
        launch   = (state_q == ST_IDLE) && !hold_q &&
                   (mode.triggered ? trig_sel : 1'b1);
        lost     = mode.triggered && trig_sel &&
                   ((state_q == ST_BUSY) || hold_q);
        state_d  = state_q;
        case (state_q)
            ST_IDLE: if (launch)   state_d = ST_BUSY;
            ST_BUSY: if (seq_done) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
            hold_q  <= 1'b0;
            drop_q  <= '0;
        end else begin
            state_q <= state_d;
            start_q <= launch;
            if (sw_hold_we) hold_q <= sw_hold_d;
            if (lost)       drop_q <= sat_inc(drop_q);
        end
    end

    assign busy       = (state_q == ST_BUSY);
    assign seq_start  = start_q;
    assign drop_count = drop_q;
endmodule

// File: rtl/trigfan_fanout.sv
module trigfan_fanout
    import trigfan_pkg::*;
#(
    parameter int NPLANE = 5,
    parameter int CTRL_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     five,
    input  logic [CTRL_W-1:0]        seq_ctrl,
    output logic [NPLANE*CTRL_W-1:0] plane_ctrl
);
    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        logic [CTRL_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else begin
                word_q <= plane_live(p, five) ? seq_ctrl : '0;
            end
        end
        assign plane_ctrl[p*CTRL_W +: CTRL_W] = word_q;
    end
endmodule

// File: rtl/trigfan_top.sv
module trigfan_top
    import trigfan_pkg::*;
#(
    parameter int NPLANE = 5,
    parameter int CTRL_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_five_planes,
    input  logic                     cfg_use_emu,
    input  logic                     cfg_triggered,
    input  logic [15:0]              cfg_emu_period,
    input  logic                     sw_hold_we,
    input  logic                     sw_hold_d,
    input  logic                     ext_trig,
    output logic                     ext_busy,
    input  logic [CTRL_W-1:0]        seq_ctrl,
    output logic                     seq_start,
    input  logic                     seq_done,
    output logic                     busy,
    output logic [15:0]              drop_count,
    output logic [NPLANE*CTRL_W-1:0] plane_ctrl
);
    trigfan_mode_t       mode_in, mode_eff;
    logic [PERIOD_W-1:0] period_eff;
    logic                emu_trig;
    logic                busy_w;

    assign mode_in = '{five: cfg_five_planes, use_emu: cfg_use_emu,
                       triggered: cfg_triggered};

    trigfan_cfg_gate u_cfg (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy_w),
        .mode_in    (mode_in),
        .period_in  (cfg_emu_period),
        .mode_eff   (mode_eff),
        .period_eff (period_eff)
    );

    trigfan_emu u_emu (
        .clk    (clk),
        .rst    (rst),
        .enable (mode_eff.use_emu),
        .busy   (busy_w),
        .period (period_eff),
        .trig   (emu_trig)
    );

    trigfan_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_eff),
        .emu_trig   (emu_trig),
        .ext_trig   (ext_trig),
        .sw_hold_we (sw_hold_we),
        .sw_hold_d  (sw_hold_d),
        .seq_done   (seq_done),
        .busy       (busy_w),
        .seq_start  (seq_start),
        .drop_count (drop_count)
    );

    trigfan_fanout #(.NPLANE(NPLANE), .CTRL_W(CTRL_W)) u_fan (
        .clk        (clk),
        .rst        (rst),
        .five       (mode_eff.five),
        .seq_ctrl   (seq_ctrl),
        .plane_ctrl (plane_ctrl)
    );

    // The external unit is kept waiting while the emulator drives triggers.
    assign ext_busy = mode_eff.use_emu | busy_w;
    assign busy     = busy_w;
endmodule

// File: rtl/trigfan_chk.sv
module trigfan_chk #(
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              seq_start,
    input logic              seq_done,
    input logic              ext_busy,
    input logic [15:0]       drop_count,
    input logic [CTRL_W-1:0] seq_ctrl,
    input logic [CTRL_W-1:0] plane0
);
    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        seq_start |=> !seq_start);

    a_r3_start_in_busy: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> busy);

    a_r3_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> !$past(busy));

    a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && seq_done) |=> !busy);

    a_r5_drop_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count == $past(drop_count)) ||
                 (drop_count == $past(drop_count) + 16'd1));

    a_r6_drop_saturates: assert property (@(posedge clk) disable iff (rst)
        (drop_count == 16'hFFFF) |=> (drop_count == 16'hFFFF));

    a_r2_plane0_echo: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (plane0 == $past(seq_ctrl)));

    a_r9_busy_visible: assert property (@(posedge clk) disable iff (rst)
        busy |-> ext_busy);
endmodule

bind trigfan_top trigfan_chk #(.CTRL_W(CTRL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .seq_start  (seq_start),
    .seq_done   (seq_done),
    .ext_busy   (ext_busy),
    .drop_count (drop_count),
    .seq_ctrl   (seq_ctrl),
    .plane0     (plane_ctrl[CTRL_W-1:0])
);

// File: tb/test_trigfan_top.sv
module test_trigfan_top;
    localparam int CW = 8;
    localparam int NP = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic cfg_five_planes = 0, cfg_use_emu = 0, cfg_triggered = 1;
    logic [15:0] cfg_emu_period = 16'd0;
    logic sw_hold_we = 0, sw_hold_d = 0, ext_trig = 0, seq_done = 0;
    logic [CW-1:0] seq_ctrl = '0;
    logic ext_busy, seq_start, busy;
    logic [15:0] drop_count;
    logic [NP*CW-1:0] plane_ctrl;

    trigfan_top #(.NPLANE(NP), .CTRL_W(CW)) i_trigfan_top (
        .clk(clk), .rst(rst), .cfg_five_planes(cfg_five_planes),
        .cfg_use_emu(cfg_use_emu), .cfg_triggered(cfg_triggered),
        .cfg_emu_period(cfg_emu_period), .sw_hold_we(sw_hold_we),
        .sw_hold_d(sw_hold_d), .ext_trig(ext_trig), .ext_busy(ext_busy),
        .seq_ctrl(seq_ctrl), .seq_start(seq_start), .seq_done(seq_done),
        .busy(busy), .drop_count(drop_count), .plane_ctrl(plane_ctrl)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [CW-1:0] plane(input int p);
        return plane_ctrl[p*CW +: CW];
    endfunction

    // Reference model built from the requirements
    logic m_busy, m_start, m_hold;
    logic [15:0] m_drop, m_cnt;
    logic s_five, s_emu, s_trig;
    logic [15:0] s_per;
    logic [NP*CW-1:0] m_plane;
    logic e_five, e_emu, e_trig, e_etrig, e_sel, e_go;
    logic [15:0] e_per;

    always_comb begin
        e_five  = m_busy ? s_five : cfg_five_planes;
        e_emu   = m_busy ? s_emu  : cfg_use_emu;
        e_trig  = m_busy ? s_trig : cfg_triggered;
        e_per   = m_busy ? s_per  : cfg_emu_period;
        e_etrig = e_emu && !m_busy && (e_per != 0) && (m_cnt >= e_per - 16'd1);
        e_sel   = e_emu ? e_etrig : ext_trig;
        e_go    = !m_hold && (e_trig ? e_sel : 1'b1);
    end

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_start <= 0; m_hold <= 0; m_drop <= 0; m_cnt <= 0;
            s_five <= 0; s_emu <= 0; s_trig <= 0; s_per <= 0; m_plane <= '0;
        end else begin
            if (sw_hold_we) m_hold <= sw_hold_d;
            m_busy  <= m_busy ? !seq_done : e_go;
            m_start <= !m_busy && e_go;
            if (e_trig && e_sel && (m_busy || m_hold) && m_drop != 16'hFFFF)
                m_drop <= m_drop + 16'd1;
            s_five <= e_five; s_emu <= e_emu; s_trig <= e_trig; s_per <= e_per;
            if (!e_emu || m_busy || e_etrig) m_cnt <= 0;
            else if (m_cnt != 16'hFFFF) m_cnt <= m_cnt + 16'd1;
            for (int p = 0; p < NP; p++)
                m_plane[p*CW +: CW] <= (p == 0 || e_five) ? seq_ctrl : '0;
        end
    end

    initial begin
        #(5ns * 190000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 busy", busy, 0); chk("R1 start", seq_start, 0);
        chk("R1 drops", drop_count, 0); chk("R1 planes", plane_ctrl, 0);
        chk("R1 ext_busy", ext_busy, 0);
        rst = 0; seq_ctrl = 8'hA5;
        cyc(1);
        chk("R1 busy after reset", busy, 0);

        // R3 accept, R2 one plane
        ext_trig = 1; cyc(1); ext_trig = 0;
        chk("R3 busy", busy, 1); chk("R3 start", seq_start, 1);
        chk("R9 ext_busy follows busy", ext_busy, 1);
        cyc(1);
        chk("R3 start one cycle", seq_start, 0);
        chk("R2 plane0", plane(0), 8'hA5); chk("R2 plane1 off", plane(1), 0);
        // R5 drop while busy
        ext_trig = 1; cyc(1); ext_trig = 0;
        chk("R5 drop while busy", drop_count, 1);
        // R4 done with simultaneous trigger
        seq_done = 1; ext_trig = 1; cyc(1); seq_done = 0; ext_trig = 0;
        chk("R4 busy cleared", busy, 0);
        chk("R5 trigger in done cycle dropped", drop_count, 2);
        seq_done = 1; cyc(1); seq_done = 0;
        chk("R4 done while idle", busy, 0);

        // R11 freeze during busy
        ext_trig = 1; cyc(1); ext_trig = 0;
        cfg_five_planes = 1; cyc(2);
        chk("R11 plane1 frozen off", plane(1), 0);
        seq_done = 1; cyc(1); seq_done = 0;
        cyc(1);
        chk("R11 plane1 live after idle", plane(1), 8'hA5);
        chk("R2 plane4", plane(4), 8'hA5);
        seq_ctrl = 8'h3C; cyc(1);
        chk("R2 plane2 tracks", plane(2), 8'h3C);
        cfg_five_planes = 0; cyc(1);
        chk("R2 plane2 off", plane(2), 0);
        chk("R2 plane0 stays", plane(0), 8'h3C);

        // R8 hold
        sw_hold_we = 1; sw_hold_d = 1; cyc(1); sw_hold_we = 0;
        ext_trig = 1; cyc(1); ext_trig = 0;
        chk("R8 hold blocks start", busy, 0);
        chk("R5 drop under hold", drop_count, 3);
        sw_hold_we = 1; sw_hold_d = 0; cyc(1); sw_hold_we = 0;
        ext_trig = 1; cyc(1); ext_trig = 0;
        chk("R8 start after release", busy, 1);
        sw_hold_we = 1; sw_hold_d = 1; cyc(1); sw_hold_we = 0;
        chk("R8 running readout continues", busy, 1);
        seq_done = 1; cyc(1); seq_done = 0;
        chk("R8 done ends readout", busy, 0);

        // R7 untriggered
        cfg_triggered = 0; cyc(3);
        chk("R8 hold blocks free-run", busy, 0);
        sw_hold_we = 1; sw_hold_d = 0; cyc(1); sw_hold_we = 0;
        cyc(1);
        chk("R7 free-run start", seq_start, 1);
        ext_trig = 1; cyc(2); ext_trig = 0;
        chk("R7 trigger not counted", drop_count, 3);
        seq_done = 1; cyc(1); seq_done = 0;
        chk("R7 busy cleared", busy, 0);
        cyc(1);
        chk("R7 restart", seq_start, 1);
        seq_done = 1; cyc(1); seq_done = 0;
        cfg_triggered = 1; cyc(2);
        chk("R7 triggered idle", busy, 0);

        // R10 emulator, R9 source select
        cfg_emu_period = 16'd4; cfg_use_emu = 1; ext_trig = 1;
        cyc(3);
        chk("R10 no early trigger", busy, 0);
        chk("R9 ext_busy held in emu", ext_busy, 1);
        cyc(1);
        chk("R10 fires on 4th cycle", seq_start, 1);
        chk("R9 ext_trig ignored", drop_count, 3);
        seq_done = 1; cyc(1); seq_done = 0;
        cyc(3);
        chk("R10 quiet after busy", seq_start, 0);
        cyc(1);
        chk("R10 fires again", seq_start, 1);
        seq_done = 1; cyc(1); seq_done = 0;
        cfg_emu_period = 16'd0; cyc(40);
        chk("R10 period zero silent", busy, 0);
        cfg_use_emu = 0; ext_trig = 0; cyc(1);
        chk("R9 ext_busy real mode", ext_busy, 0);

        // R6 saturation
        sw_hold_we = 1; sw_hold_d = 1; cyc(1); sw_hold_we = 0;
        ext_trig = 1; cyc(65540);
        chk("R6 saturated", drop_count, 16'hFFFF);
        cyc(5);
        chk("R6 stays saturated", drop_count, 16'hFFFF);
        ext_trig = 0;

        // Random phase against the model
        rst = 1; cyc(2); rst = 0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            chk("R3 busy model", busy, m_busy);
            chk("R3 start model", seq_start, m_start);
            chk("R5 drops model", drop_count, m_drop);
            chk("R9 ext_busy model", ext_busy, e_emu | m_busy);
            chk("R2 planes model", plane_ctrl, m_plane);
            if ($urandom_range(15) == 0) cfg_five_planes = $urandom_range(1);
            if ($urandom_range(15) == 0) cfg_use_emu = $urandom_range(1);
            if ($urandom_range(15) == 0) cfg_triggered = $urandom_range(1);
            if ($urandom_range(31) == 0) cfg_emu_period = 16'($urandom_range(8));
            sw_hold_we = ($urandom_range(19) == 0);
            sw_hold_d  = ($urandom_range(3) == 0);
            ext_trig   = ($urandom_range(9) < 3);
            seq_done   = ($urandom_range(9) < 3);
            seq_ctrl   = CW'($urandom);
            cyc(1);
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule